// File: doc/BRIEF.md
# Overwrite-and-advance hit recorder

This block logs, into a small dual-port memory, the candidate words that a hash checker accepts. The checker's verdict comes late, after the next candidate has already been issued. So every candidate word is written at once into the slot under the write pointer. When an accept pulse arrives, the pointer steps forward and the word now in that slot is kept. When no accept arrives, the next word simply replaces it.

With a verdict that lags by one candidate, each kept word is the accepted candidate plus one, so the host subtracts one. The last slot written after the final accept holds a word that was never accepted. The hit count output gives the number of kept entries, and the host uses it to drop that trailing slot.

The write pointer stops at the memory depth. Any accept after that point raises a sticky overflow flag. The host reads the memory through a separate synchronous read port, which has its own clock input.

Top module: `hit_recorder`

## Requirements
- R1: While rst_ni is low, hit_count_o is 0, overflow_o is 0 and rd_data_o is 0.
- R2: A word presented with wr_valid_i high is stored in the slot given by the current hit count. Presenting that slot on rd_addr_i returns the word on rd_data_o one rd_clk_i edge later.
- R3: A write with no accept leaves hit_count_o unchanged, and the next write overwrites the same slot.
- R4: Each accept_i pulse increases hit_count_o by one, and the word in the slot it leaves is kept.
- R5: When wr_valid_i and accept_i are high in the same cycle, the word goes to the old slot, and that slot is then kept.
- R6: An accept with wr_valid_i low still advances the pointer. The slot it leaves keeps the last word written there.
- R7: Once hit_count_o equals DEPTH it stays there. Further writes do not change memory, and an accept in that state sets overflow_o, which stays high until reset.
- R8: A read of the slot being written in the same cycle returns the contents from before that write.
- R9: When accepts lag their candidates by one word, slots 0 to hit_count_o-1 hold the accepted candidates plus one, and the slot at hit_count_o holds the last word issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Write-side clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Candidate word strobe |
| wr_data_i | input | WIDTH | Candidate word |
| accept_i | input | 1 | Delayed accept pulse, keeps the current slot |
| rd_clk_i | input | 1 | Host read clock |
| rd_addr_i | input | AW | Host read slot |
| rd_data_o | output | WIDTH | Registered read data |
| hit_count_o | output | PW | Number of kept entries |
| overflow_o | output | 1 | Sticky: an accept arrived while the memory was full |

## Verification
The write pointer, hit count and overflow flag all register on the clk_i edge that samples accept_i, so they are due one edge after the stimulus. A memory write lands on that same edge. Read data is due one rd_clk_i edge after the address is presented. The bench drives all inputs on the falling edge and samples on the next falling edge, so exactly one rising edge lies between stimulus and check. Reads of written slots always begin after the write edge, except in the collision case, where the address is presented in the same cycle as the write on purpose.

// File: rtl/hit_rec_pkg.sv
package hit_rec_pkg;
  localparam int unsigned HR_WIDTH_DEF = 16;
  localparam int unsigned HR_DEPTH_DEF = 16;
endpackage

// File: rtl/hit_rec_ptr.sv
module hit_rec_ptr #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned PW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic          accept_i,
  output logic          wr_en_o,
  output logic [PW-1:0] slot_o,
  output logic          full_o,
  output logic          ovf_o
);
  localparam logic [PW-1:0] FULL = PW'(DEPTH);

  logic [PW-1:0] ptr_q;
  logic          ovf_q;

  assign full_o  = (ptr_q == FULL);
  assign wr_en_o = wr_valid_i & ~full_o;
  assign slot_o  = ptr_q;
  assign ovf_o   = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      ovf_q <= 1'b0;
    end else if (accept_i) begin
      if (!full_o) ptr_q <= ptr_q + 1'b1;
      else         ovf_q <= 1'b1;
    end
  end

  p_advance_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i && !full_o |=> slot_o == $past(slot_o) + 1'b1);
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> $stable(slot_o));
  p_no_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_o <= FULL);
  p_ovf_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  p_ovf_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(full_o && accept_i));
endmodule

// File: rtl/hit_rec_dpram.sv
module hit_rec_dpram #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic             wr_clk_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [WIDTH-1:0] rd_data_o
);
  localparam int unsigned   AW1   = AW + 1;
  localparam logic [AW:0]   LIMIT = AW1'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  // read-before-write on a shared slot
  always_ff @(posedge rd_clk_i or negedge rst_ni) begin
    if (!rst_ni)                       rd_data_o <= '0;
    else if ({1'b0, rd_addr_i} < LIMIT) rd_data_o <= mem[rd_addr_i];
    else                               rd_data_o <= '0;
  end

  p_wr_in_range_r2: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    wr_en_i |-> {1'b0, wr_addr_i} < LIMIT);
endmodule

// File: rtl/hit_recorder.sv
module hit_recorder
  import hit_rec_pkg::*;
#(
  parameter int unsigned WIDTH = HR_WIDTH_DEF,
  parameter int unsigned DEPTH = HR_DEPTH_DEF,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned PW    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             accept_i,
  input  logic             rd_clk_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic [PW-1:0]    hit_count_o,
  output logic             overflow_o
);
  logic          wr_en;
  logic          full;
  logic [PW-1:0] slot;

  hit_rec_ptr #(.DEPTH(DEPTH), .PW(PW)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .accept_i   (accept_i),
    .wr_en_o    (wr_en),
    .slot_o     (slot),
    .full_o     (full),
    .ovf_o      (overflow_o)
  );

  hit_rec_dpram #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .wr_clk_i  (clk_i),
    .wr_en_i   (wr_en),
    .wr_addr_i (slot[AW-1:0]),
    .wr_data_i (wr_data_i),
    .rd_clk_i  (rd_clk_i),
    .rst_ni    (rst_ni),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  assign hit_count_o = slot;

  p_full_blocks_wr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full |-> !wr_en);
  p_wr_follows_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> wr_valid_i);
endmodule

// File: tb/hit_recorder_tb.sv
module hit_recorder_tb;
  localparam int W = 16;
  localparam int D = 16;
  localparam int AW = $clog2(D);
  localparam int PW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_valid = 1'b0;
  logic [W-1:0]  wr_data = '0;
  logic          accept = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [W-1:0]  rd_data;
  logic [PW-1:0] hit_count;
  logic          overflow;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  hit_recorder u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .accept_i(accept), .rd_clk_i(clk), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .hit_count_o(hit_count), .overflow_o(overflow)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic wv, input logic [W-1:0] wd, input logic acc);
    wr_valid = wv; wr_data = wd; accept = acc;
    @(negedge clk);
    wr_valid = 1'b0; accept = 1'b0;
  endtask

  task automatic rd(input int addr, output int val);
    rd_addr = AW'(addr);
    @(negedge clk);
    val = int'(rd_data);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    wr_valid = 1'b0; accept = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1", "hit_count", int'(hit_count), 0);
    check("R1", "overflow", int'(overflow), 0);
    check("R1", "rd_data", int'(rd_data), 0);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_overwrite();
    int v;
    do_reset();
    step(1'b1, 16'h1111, 1'b0);
    rd(0, v);
    check("R2", "slot0 after write", v, 16'h1111);
    step(1'b1, 16'h2222, 1'b0);
    check("R3", "count after plain write", int'(hit_count), 0);
    rd(0, v);
    check("R3", "slot0 overwritten", v, 16'h2222);
  endtask

  task automatic t_accept();
    int v;
    do_reset();
    step(1'b1, 16'hAAAA, 1'b0);
    step(1'b0, '0, 1'b1);
    check("R4", "count after accept", int'(hit_count), 1);
    check("R6", "accept without write advanced", int'(hit_count), 1);
    step(1'b1, 16'hBBBB, 1'b0);
    step(1'b1, 16'hCCCC, 1'b0);
    rd(0, v);
    check("R6", "kept slot0", v, 16'hAAAA);
    rd(1, v);
    check("R4", "slot1 overwritten last", v, 16'hCCCC);
  endtask

  task automatic t_stream();
    int v;
    do_reset();
    for (int i = 100; i < 110; i++)
      step(1'b1, W'(i), (i == 104) || (i == 108));
    check("R9", "hit count", int'(hit_count), 2);
    rd(0, v);
    check("R5", "same-cycle write kept", v, 104);
    check("R9", "slot0 minus one", v - 1, 103);
    rd(1, v);
    check("R9", "slot1 minus one", v - 1, 107);
    rd(2, v);
    check("R9", "trailing last word", v, 109);
  endtask

  task automatic t_collision();
    int v;
    do_reset();
    step(1'b1, 16'h0A0A, 1'b0);
    rd_addr = '0;
    step(1'b1, 16'h0B0B, 1'b0);
    v = int'(rd_data);
    check("R8", "read during write sees old", v, 16'h0A0A);
    rd(0, v);
    check("R8", "read after write sees new", v, 16'h0B0B);
  endtask

  task automatic t_saturate();
    int v;
    do_reset();
    for (int i = 0; i < D; i++)
      step(1'b1, W'(16'h5000 + i), 1'b1);
    check("R7", "count at full", int'(hit_count), D);
    check("R7", "no overflow yet", int'(overflow), 0);
    step(1'b1, 16'hDEAD, 1'b0);
    rd(D - 1, v);
    check("R7", "last slot untouched", v, 16'h5000 + D - 1);
    rd(0, v);
    check("R7", "slot0 untouched", v, 16'h5000);
    step(1'b0, '0, 1'b1);
    check("R7", "overflow set", int'(overflow), 1);
    check("R7", "count holds", int'(hit_count), D);
    step(1'b0, '0, 1'b0);
    step(1'b0, '0, 1'b0);
    check("R7", "overflow sticky", int'(overflow), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_overwrite();
    t_accept();
    t_stream();
    t_collision();
    t_saturate();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule